// File: doc/BRIEF.md
# Audio Serial FIFO with DMA Request Control

This block sits between a system DMA engine and a multichannel audio serial port. It holds two word queues: one for transmit, filled by the DMA and drained by the serial side, and one for receive, filled by the serial side and drained by the DMA. Each word is 32 bits wide. It holds either a full 32-bit sample or a 16-bit sample with the upper half forced to zero. The serial side is modelled as a word strobe with one word per channel slot. Slots always follow channel order, so a frame occupies as many words as there are channels.

Each direction raises a DMA request from its own threshold. The receive request follows the receive fill level directly. The transmit request is raised when there is enough free space for a burst. It is then dropped after exactly one threshold's worth of accepted DMA writes, whatever the fill level is at that point. A one-cycle warning pulse flags that transmit free space is close to the request point. Sticky underflow and overflow flags, cleared by write-one-to-clear strobes, report serial-side starvation and loss. The fill levels and the frame capacity for the selected channel count are visible on the ports.

Top module: `audfifo_dma`

## Requirements
- R1: Each queue holds DEPTH (1280) words. `txFill` and `rxFill` change at the clock edge of the push or pop that alters them. A DMA write while the transmit queue is full is dropped.
- R2: Each `serTxStrobe` pops one transmit word, in write order, and never skips a word. `txSlot` shows the channel index of the word at the head. It advances by one on every strobe and wraps to 0 after slot 2^`chanSel`-1. `rxSlot` behaves the same way on `serRxStrobe`.
- R3: A `serTxStrobe` while the transmit queue is empty outputs `serTxData` = 0 and sets `underflow`. The flag stays set until a cycle with `statusClr` bit 0 high.
- R4: A `serRxStrobe` while the receive queue is full drops the word and leaves `rxFill` at DEPTH. It sets `overflow`, which stays set until a cycle with `statusClr` bit 1 high.
- R5: `rxReq` is high exactly when `rxFill` >= `rxThresh`.
- R6: While no transmit burst is open, `txReq` rises one clock after free space (DEPTH - `txFill`) is at least `txThresh`.
- R7: Once `txReq` is high, it falls at the edge of the `txThresh`-th accepted DMA write of that burst, even when free space is still at least `txThresh`. It does not fall before that write.
- R8: `txWarnIrq` pulses high for one cycle when free space first lies in the range `txThresh`-WARN_MARGIN up to `txThresh`-1 (WARN_MARGIN = 4).
- R9: With `wordIs16` high, bits 31:16 of every stored word are zero in both directions.
- R10: `frameCap` equals DEPTH >> `chanSel`, that is 1280, 640 or 320 frames for one, two or four channels.
- R11: A threshold change takes effect on the request outputs without changing either fill level or the queued data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dmaTxWrEn | input | 1 | DMA writes one transmit word |
| dmaTxWrData | input | 32 | Transmit word from DMA |
| dmaRxRdEn | input | 1 | DMA takes the head receive word |
| dmaRxRdData | output | 32 | Head receive word, 0 when empty |
| serTxStrobe | input | 1 | Serial side consumes one transmit word |
| serTxData | output | 32 | Head transmit word, 0 when empty |
| serRxStrobe | input | 1 | Serial side delivers one receive word |
| serRxData | input | 32 | Receive word from serial side |
| txThresh | input | 11 | Transmit burst size / free-space trigger (1..1280) |
| rxThresh | input | 11 | Receive request level (1..1280) |
| chanSel | input | 2 | log2 of channel count |
| wordIs16 | input | 1 | Zero the upper half of stored words |
| statusClr | input | 2 | Write-one-to-clear: bit 0 underflow, bit 1 overflow |
| txReq | output | 1 | Transmit DMA request |
| rxReq | output | 1 | Receive DMA request |
| txWarnIrq | output | 1 | One-cycle near-threshold warning |
| underflow | output | 1 | Sticky transmit underflow |
| overflow | output | 1 | Sticky receive overflow |
| txFill | output | 11 | Transmit words held |
| rxFill | output | 11 | Receive words held |
| txSlot | output | 3 | Channel index of next transmit word |
| rxSlot | output | 3 | Channel index of next receive word |
| frameCap | output | 11 | Frames that fit in one queue |

## Verification
A wrong pointer or fill counter shows up on the serial or DMA data ports the moment the affected word reaches the head of the queue. A counter that drifts from the true content shows up on `txFill` or `rxFill` at the very next edge. A burst counter that is off by one is visible one edge early or late on `txReq`. Writing a burst into a nearly empty queue, where a level-based request would stay high, makes that difference visible. A stale slot counter shows up on `txSlot` at the next strobe, so channel misalignment cannot stay hidden for longer than one frame.

// File: rtl/audfifo_pkg.sv
package audfifo_pkg;
  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
    logic padLow;
  } ctlStrobes_t;
endpackage

// File: rtl/audfifo_ring.sv
module audfifo_ring #(
  parameter int DEPTH = 1280,
  parameter int WIDTH = 32,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head = mem[rdPtr];
endmodule

// File: rtl/audfifo_datapath.sv
module audfifo_datapath
  import audfifo_pkg::*;
#(
  parameter int DEPTH = 1280,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t stb,
  input  logic [31:0] dmaTxWrData,
  input  logic [31:0] serRxData,
  output logic [31:0] serTxData,
  output logic [31:0] dmaRxRdData,
  output logic [CW-1:0] txFill,
  output logic [CW-1:0] rxFill
);
  logic [31:0] padMask, txHead, rxHead;
  assign padMask = stb.padLow ? 32'h0000_FFFF : 32'hFFFF_FFFF;

  audfifo_ring #(.DEPTH(DEPTH), .WIDTH(32)) u_txRing (
    .clk(clk), .rstN(rstN), .push(stb.txPush), .pop(stb.txPop),
    .din(dmaTxWrData & padMask), .head(txHead), .count(txFill));

  audfifo_ring #(.DEPTH(DEPTH), .WIDTH(32)) u_rxRing (
    .clk(clk), .rstN(rstN), .push(stb.rxPush), .pop(stb.rxPop),
    .din(serRxData & padMask), .head(rxHead), .count(rxFill));

  assign serTxData   = (txFill == '0) ? '0 : txHead;
  assign dmaRxRdData = (rxFill == '0) ? '0 : rxHead;
endmodule

// File: rtl/audfifo_ctrl.sv
module audfifo_ctrl
  import audfifo_pkg::*;
#(
  parameter int DEPTH = 1280,
  parameter int WARN_MARGIN = 4,
  parameter int CHSEL_W = 2,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int SLOT_W = (1 << CHSEL_W) - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dmaTxWrEn,
  input  logic              dmaRxRdEn,
  input  logic              serTxStrobe,
  input  logic              serRxStrobe,
  input  logic [CW-1:0]     txFill,
  input  logic [CW-1:0]     rxFill,
  input  logic [CW-1:0]     txThresh,
  input  logic [CW-1:0]     rxThresh,
  input  logic [CHSEL_W-1:0] chanSel,
  input  logic              wordIs16,
  input  logic [1:0]        statusClr,
  output ctlStrobes_t       stb,
  output logic              txReq,
  output logic              rxReq,
  output logic              txWarnIrq,
  output logic              underflow,
  output logic              overflow,
  output logic [SLOT_W-1:0] txSlot,
  output logic [SLOT_W-1:0] rxSlot,
  output logic [CW-1:0]     frameCap
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [CW-1:0] txFree, burstCnt;
  logic [CW:0]   warnSum;
  logic          warnLevel, warnQ;
  logic [SLOT_W-1:0] lastSlot;

  assign stb.txPush = dmaTxWrEn && (txFill != FULL);
  assign stb.txPop  = serTxStrobe && (txFill != '0);
  assign stb.rxPush = serRxStrobe && (rxFill != FULL);
  assign stb.rxPop  = dmaRxRdEn && (rxFill != '0);
  assign stb.padLow = wordIs16;

  assign txFree    = FULL - txFill;
  assign rxReq     = (rxFill >= rxThresh);
  assign warnSum   = {1'b0, txFree} + (CW + 1)'(WARN_MARGIN);
  assign warnLevel = (warnSum >= {1'b0, txThresh}) && (txFree < txThresh);
  assign txWarnIrq = warnLevel && !warnQ;
  assign frameCap  = FULL >> chanSel;
  assign lastSlot  = SLOT_W'((1 << chanSel) - 1);

  // Transmit burst: raised on free space, dropped on count of accepted writes.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txReq    <= 1'b0;
      burstCnt <= '0;
    end else if (!txReq) begin
      burstCnt <= '0;
      if (txFree >= txThresh) txReq <= 1'b1;
    end else if (stb.txPush) begin
      if (burstCnt + 1'b1 >= txThresh) txReq <= 1'b0;
      else burstCnt <= burstCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      warnQ     <= 1'b0;
      underflow <= 1'b0;
      overflow  <= 1'b0;
      txSlot    <= '0;
      rxSlot    <= '0;
    end else begin
      warnQ     <= warnLevel;
      underflow <= (underflow && !statusClr[0]) || (serTxStrobe && txFill == '0);
      overflow  <= (overflow && !statusClr[1]) || (serRxStrobe && rxFill == FULL);
      if (serTxStrobe) txSlot <= (txSlot >= lastSlot) ? '0 : txSlot + 1'b1;
      if (serRxStrobe) rxSlot <= (rxSlot >= lastSlot) ? '0 : rxSlot + 1'b1;
    end
  end
endmodule

// File: rtl/audfifo_dma.sv
module audfifo_dma
  import audfifo_pkg::*;
#(
  parameter int DEPTH = 1280,
  parameter int WARN_MARGIN = 4,
  parameter int CHSEL_W = 2,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int SLOT_W = (1 << CHSEL_W) - 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               dmaTxWrEn,
  input  logic [31:0]        dmaTxWrData,
  input  logic               dmaRxRdEn,
  output logic [31:0]        dmaRxRdData,
  input  logic               serTxStrobe,
  output logic [31:0]        serTxData,
  input  logic               serRxStrobe,
  input  logic [31:0]        serRxData,
  input  logic [CW-1:0]      txThresh,
  input  logic [CW-1:0]      rxThresh,
  input  logic [CHSEL_W-1:0] chanSel,
  input  logic               wordIs16,
  input  logic [1:0]         statusClr,
  output logic               txReq,
  output logic               rxReq,
  output logic               txWarnIrq,
  output logic               underflow,
  output logic               overflow,
  output logic [CW-1:0]      txFill,
  output logic [CW-1:0]      rxFill,
  output logic [SLOT_W-1:0]  txSlot,
  output logic [SLOT_W-1:0]  rxSlot,
  output logic [CW-1:0]      frameCap
);
  ctlStrobes_t stb;

  audfifo_ctrl #(.DEPTH(DEPTH), .WARN_MARGIN(WARN_MARGIN), .CHSEL_W(CHSEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .dmaTxWrEn(dmaTxWrEn), .dmaRxRdEn(dmaRxRdEn),
    .serTxStrobe(serTxStrobe), .serRxStrobe(serRxStrobe),
    .txFill(txFill), .rxFill(rxFill), .txThresh(txThresh), .rxThresh(rxThresh),
    .chanSel(chanSel), .wordIs16(wordIs16), .statusClr(statusClr), .stb(stb),
    .txReq(txReq), .rxReq(rxReq), .txWarnIrq(txWarnIrq),
    .underflow(underflow), .overflow(overflow),
    .txSlot(txSlot), .rxSlot(rxSlot), .frameCap(frameCap));

  audfifo_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .dmaTxWrData(dmaTxWrData),
    .serRxData(serRxData), .serTxData(serTxData), .dmaRxRdData(dmaRxRdData),
    .txFill(txFill), .rxFill(rxFill));
endmodule

// File: rtl/audfifo_checker.sv
module audfifo_checker #(
  parameter int DEPTH = 1280,
  parameter int CHSEL_W = 2,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int SLOT_W = (1 << CHSEL_W) - 1
) (
  input logic               clk,
  input logic               rstN,
  input logic               dmaTxWrEn,
  input logic [31:0]        dmaTxWrData,
  input logic               dmaRxRdEn,
  input logic [31:0]        dmaRxRdData,
  input logic               serTxStrobe,
  input logic [31:0]        serTxData,
  input logic               serRxStrobe,
  input logic [31:0]        serRxData,
  input logic [CW-1:0]      txThresh,
  input logic [CW-1:0]      rxThresh,
  input logic [CHSEL_W-1:0] chanSel,
  input logic               wordIs16,
  input logic [1:0]         statusClr,
  input logic               txReq,
  input logic               rxReq,
  input logic               txWarnIrq,
  input logic               underflow,
  input logic               overflow,
  input logic [CW-1:0]      txFill,
  input logic [CW-1:0]      rxFill,
  input logic [SLOT_W-1:0]  txSlot,
  input logic [SLOT_W-1:0]  rxSlot,
  input logic [CW-1:0]      frameCap
);
  assert_fill_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    (txFill <= CW'(DEPTH)) && (rxFill <= CW'(DEPTH)));

  assert_tx_idle_stable_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!dmaTxWrEn && !serTxStrobe) |=> $stable(txFill));

  assert_underflow_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (serTxStrobe && txFill == '0) |-> (serTxData == '0));

  assert_underflow_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && !statusClr[0]) |=> underflow);

  assert_overflow_drop_R4: assert property (@(posedge clk) disable iff (!rstN)
    (serRxStrobe && !dmaRxRdEn && rxFill == CW'(DEPTH)) |=> (rxFill == CW'(DEPTH)) && overflow);

  assert_txreq_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (txReq && !dmaTxWrEn) |=> txReq);

  assert_warn_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    txWarnIrq |=> !txWarnIrq);

  assert_pad_R9: assert property (@(posedge clk) disable iff (!rstN)
    (serRxStrobe && wordIs16 && rxFill == '0 && !dmaRxRdEn) |=> (dmaRxRdData[31:16] == 16'h0));
endmodule

bind audfifo_dma audfifo_checker #(.DEPTH(DEPTH), .CHSEL_W(CHSEL_W)) u_chk (.*);

// File: tb/test_audfifo_dma.sv
module test_audfifo_dma;
  localparam int DEPTH = 1280;
  localparam int CW = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dmaTxWrEn = 0, dmaRxRdEn = 0, serTxStrobe = 0, serRxStrobe = 0, wordIs16 = 0;
  logic [31:0] dmaTxWrData = 0, serRxData = 0;
  logic [CW-1:0] txThresh = 11'd4, rxThresh = 11'd4;
  logic [1:0] chanSel = 2'd1, statusClr = 2'd0;
  logic [31:0] dmaRxRdData, serTxData;
  logic txReq, rxReq, txWarnIrq, underflow, overflow;
  logic [CW-1:0] txFill, rxFill, frameCap;
  logic [2:0] txSlot, rxSlot;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  audfifo_dma i_audfifo_dma (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; dmaTxWrEn = 0; dmaRxRdEn = 0; serTxStrobe = 0; serRxStrobe = 0;
    wordIs16 = 0; statusClr = 0; txThresh = 11'd4; rxThresh = 11'd4; chanSel = 2'd1;
    repeat (2) @(negedge clk);
    rstN = 1;
  endtask

  task automatic txWrite(input logic [31:0] d);
    dmaTxWrEn = 1; dmaTxWrData = d;
    @(negedge clk);
    dmaTxWrEn = 0;
  endtask

  task automatic rxPushWord(input logic [31:0] d);
    serRxStrobe = 1; serRxData = d;
    @(negedge clk);
    serRxStrobe = 0;
  endtask

  task automatic testReset();
    rstN = 0;
    repeat (2) @(negedge clk);
    chk("R1 reset txFill", 32'(txFill), 0);
    chk("R1 reset rxFill", 32'(rxFill), 0);
    chk("R6 reset txReq", 32'(txReq), 0);
    chk("R3 reset underflow", 32'(underflow), 0);
    chk("R4 reset overflow", 32'(overflow), 0);
  endtask

  task automatic testTxBurst();
    doReset();
    @(negedge clk);
    chk("R6 txReq rises", 32'(txReq), 1);
    for (int i = 0; i < 3; i++) begin
      txWrite(32'h100 + 32'(i));
      chk("R7 txReq held mid-burst", 32'(txReq), 1);
    end
    txWrite(32'h103);
    chk("R7 txReq drops after count", 32'(txReq), 0);
    chk("R1 txFill after burst", 32'(txFill), 4);
    @(negedge clk);
    chk("R6 txReq re-raised", 32'(txReq), 1);
  endtask

  task automatic testTxOrder();
    logic [31:0] exp [4];
    exp = '{32'h11, 32'h22, 32'h33, 32'h44};
    doReset();
    for (int i = 0; i < 4; i++) txWrite(exp[i]);
    for (int k = 0; k < 4; k++) begin
      chk("R2 tx order", serTxData, exp[k]);
      chk("R2 tx slot", 32'(txSlot), 32'(k % 2));
      serTxStrobe = 1;
      @(negedge clk);
      serTxStrobe = 0;
    end
    chk("R1 txFill drained", 32'(txFill), 0);
    chk("R3 no underflow yet", 32'(underflow), 0);
  endtask

  task automatic testUnderflow();
    doReset();
    chk("R3 empty output zero", serTxData, 0);
    serTxStrobe = 1;
    @(negedge clk);
    serTxStrobe = 0;
    chk("R3 underflow set", 32'(underflow), 1);
    chk("R2 slot advances on empty", 32'(txSlot), 1);
    repeat (2) @(negedge clk);
    chk("R3 underflow sticky", 32'(underflow), 1);
    statusClr = 2'b10;
    @(negedge clk);
    chk("R3 wrong bit no clear", 32'(underflow), 1);
    statusClr = 2'b01;
    @(negedge clk);
    statusClr = 0;
    chk("R3 underflow cleared", 32'(underflow), 0);
  endtask

  task automatic testRxThresh();
    doReset();
    rxThresh = 11'd3;
    rxPushWord(32'hA1);
    rxPushWord(32'hA2);
    chk("R5 rxReq below", 32'(rxReq), 0);
    chk("R2 rx slot", 32'(rxSlot), 0);
    rxPushWord(32'hA3);
    chk("R5 rxReq at level", 32'(rxReq), 1);
    chk("R2 rx head", dmaRxRdData, 32'hA1);
    dmaRxRdEn = 1;
    @(negedge clk);
    dmaRxRdEn = 0;
    chk("R5 rxReq after read", 32'(rxReq), 0);
    chk("R2 rx next", dmaRxRdData, 32'hA2);
    rxThresh = 11'd2;
    #1;
    chk("R11 rxReq new thresh", 32'(rxReq), 1);
    chk("R11 rxFill kept", 32'(rxFill), 2);
    chk("R11 data kept", dmaRxRdData, 32'hA2);
  endtask

  task automatic testOverflow();
    doReset();
    serRxStrobe = 1;
    for (int i = 0; i < DEPTH; i++) begin
      serRxData = 32'(i);
      @(negedge clk);
    end
    serRxData = 32'hFFFF;
    @(negedge clk);
    serRxStrobe = 0;
    chk("R4 rxFill stays full", 32'(rxFill), DEPTH);
    chk("R4 overflow set", 32'(overflow), 1);
    chk("R4 head intact", dmaRxRdData, 0);
    dmaRxRdEn = 1;
    @(negedge clk);
    dmaRxRdEn = 0;
    chk("R1 rxFill after read", 32'(rxFill), DEPTH - 1);
    chk("R4 overflow sticky", 32'(overflow), 1);
    statusClr = 2'b10;
    @(negedge clk);
    statusClr = 0;
    chk("R4 overflow cleared", 32'(overflow), 0);
  endtask

  task automatic testTxFull();
    doReset();
    dmaTxWrEn = 1;
    for (int i = 0; i < DEPTH + 1; i++) begin
      dmaTxWrData = 32'(i);
      @(negedge clk);
    end
    dmaTxWrEn = 0;
    chk("R1 tx full", 32'(txFill), DEPTH);
    chk("R1 tx head", serTxData, 0);
  endtask

  task automatic testPad();
    doReset();
    wordIs16 = 1;
    txWrite(32'hDEADBEEF);
    chk("R9 tx padded", serTxData, 32'h0000BEEF);
    rxPushWord(32'hCAFEF00D);
    chk("R9 rx padded", dmaRxRdData, 32'h0000F00D);
  endtask

  task automatic testFrameCap();
    doReset();
    chanSel = 2'd0; #1;
    chk("R10 mono", 32'(frameCap), 1280);
    chanSel = 2'd1; #1;
    chk("R10 stereo", 32'(frameCap), 640);
    chanSel = 2'd2; #1;
    chk("R10 four ch", 32'(frameCap), 320);
  endtask

  task automatic testWarn();
    doReset();
    for (int i = 0; i < 10; i++) txWrite(32'(i));
    txThresh = 11'd1275;
    @(negedge clk);
    chk("R8 no warn yet", 32'(txWarnIrq), 0);
    chk("R11 txFill kept", 32'(txFill), 10);
    serTxStrobe = 1;
    @(negedge clk);
    serTxStrobe = 0;
    chk("R8 warn pulse", 32'(txWarnIrq), 1);
    @(negedge clk);
    chk("R8 warn one cycle", 32'(txWarnIrq), 0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    testReset();
    testTxBurst();
    testTxOrder();
    testUnderflow();
    testRxThresh();
    testOverflow();
    testTxFull();
    testPad();
    testFrameCap();
    testWarn();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule